// File: doc/BRIEF.md
# Dual-Plane NAND Page Program Sequencer

This block sits on the controller side of an asynchronous byte-wide NAND flash bus and writes two pages at once, one into each plane of the die. A request carries two 40-bit page addresses (16-bit column in the low bits, 24-bit row above it). The block checks that the addresses point into opposite planes and loads the first page under the ordinary program opcode. It closes that page with an intermediate confirm, waits for the device to come back ready, and then loads the second page under the multi-plane opcode. The final confirm starts both planes programming together.

Page bytes come from a byte-wide valid/ready source and are written in the order they arrive. After the final confirm the block waits on the ready/busy line and polls the status byte until the device reports that it has finished. If the status byte shows a failure, the block queries each plane in turn with an enhanced status read to find which page failed. Each ready/busy wait is bounded by a cycle counter. When that counter runs out, the block ends the operation with a timeout error, which is reported separately from a program failure.

The result is reported as a one-cycle `done` strobe, together with flags that hold their value until the next request is accepted. Every strobe timing is a fixed number of clock cycles set by parameters.

Top module: `nand_dual_plane_prog`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken only when `req_valid` and `req_ready` are both high, and `req_valid` held high during an operation does not restart it or change its bus sequence.
- R2: The plane bit is bit 6 of the row, which is bit 22 of the 40-bit address. If that bit is 1 in `req_addr0` or 0 in `req_addr1`, the request is refused. No bus cycle takes place and `nand_ce_n` stays high. `done` rises in the cycle after acceptance, with `err_reject` = 1.
- R3: The first phase writes command 80h and then five address cycles. The address bytes go out in this order: column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8, row bits 23:16. Then come PAGE_BYTES data cycles taken from the source, and finally command 11h.
- R4: After 11h, no bus cycle occurs until ready/busy has been seen high after the write-to-busy delay. The second phase then writes command 81h, five address cycles for `req_addr1` in the same byte order, PAGE_BYTES further source bytes, and command 10h.
- R5: Once ready/busy is high after 10h, the block writes command 70h and reads one status byte. While bit 6 of that byte is 0, it writes 70h and reads again.
- R6: If the status byte has bit 6 = 1 and bit 0 = 0, the operation ends with `fail_plane0` = `fail_plane1` = 0 and no error flag set.
- R7: If the status byte has bit 0 = 1, the block writes command 78h with the three row bytes of page 0, lowest byte first, and reads one byte. It then does the same for page 1. `fail_plane0` and `fail_plane1` take bit 0 of the respective read.
- R8: If ready/busy stays low for TIMEOUT_CYCLES cycles of waiting, the operation ends with `err_timeout` = 1 and no further bus cycle is issued.
- R9: `nand_ce_n` is high while idle. The command latch enable is high only during command cycles and the address latch enable only during address cycles. Each write or read cycle drives its strobe low in the cycle after the cycle is started.
- R10: `done` is high for exactly one cycle. `fail_plane0`, `fail_plane1`, `err_timeout` and `err_reject` keep their values from `done` until the next request is accepted.
- R11: A source byte is consumed only in a cycle where `src_valid` and `src_ready` are both high, and such a cycle always starts a write-enable pulse in the next cycle. Gaps in `src_valid` stall loading without dropping or repeating bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr0 | input | 40 | Page address for plane 0 (row in bits 39:16, column in bits 15:0) |
| req_addr1 | input | 40 | Page address for plane 1 |
| src_valid | input | 1 | Source byte available |
| src_ready | output | 1 | Source byte taken this cycle when valid |
| src_data | input | 8 | Source byte |
| done | output | 1 | One-cycle completion strobe |
| fail_plane0 | output | 1 | Plane 0 page failed to program |
| fail_plane1 | output | 1 | Plane 1 page failed to program |
| err_timeout | output | 1 | A ready/busy wait ran out |
| err_reject | output | 1 | Request refused on plane-bit check |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus input value |
| nand_rb_n | input | 1 | Ready (high) / busy (low) from the device |

## Verification
Two things can meet in one cycle: the completion strobe of one operation and a request for the next. The bench holds `req_valid` high through a whole operation and across its `done` cycle. It then checks that the bus log contains exactly one sequence with no restart, that `req_ready` is low while `done` is high, and that `req_ready` returns in the following cycle while the flags keep their values. A second case is a status poll that finds the device still working after ready/busy has returned. The device model reports bit 6 = 0 for a set number of reads, and the bench counts the 70h commands in the log.

// File: rtl/nand_mp_pkg.sv
package nand_mp_pkg;
  typedef enum logic [1:0] {
    BUS_CMD  = 2'd0,
    BUS_ADDR = 2'd1,
    BUS_DATA = 2'd2,
    BUS_READ = 2'd3
  } bus_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_C_SETUP, S_ADDR, S_DATA, S_C_CONF, S_WAIT_WB, S_WAIT_RB,
    S_C_STAT, S_RD_STAT, S_C_ENH, S_ENH_ADDR, S_RD_ENH, S_FINISH
  } seq_state_e;

  localparam int unsigned PAGE_ADDR_W = 40;
endpackage

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == CW'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (en && !expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_mp_pkg::*;
#(
  parameter int unsigned LO_CYC = 2,
  parameter int unsigned HI_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  bus_kind_e  kind,
  input  logic [7:0] wbyte,
  output logic       busy,
  output logic       ack,
  output logic [7:0] rbyte,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] dq_o,
  output logic       dq_oe,
  input  logic [7:0] dq_i
);
  localparam int unsigned TOT = LO_CYC + HI_CYC;
  localparam int unsigned CW  = $clog2(TOT + 1);

  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  bus_kind_e     kind_q, kind_d;
  logic [7:0]    byte_q, byte_d, rb_q, rb_d;
  logic          low_ph;

  assign low_ph = act_q && (cnt_q < CW'(LO_CYC));
  assign busy   = act_q;
  assign ack    = act_q && (cnt_q == CW'(TOT - 1));
  assign rbyte  = rb_q;
  assign cle    = act_q && (kind_q == BUS_CMD);
  assign ale    = act_q && (kind_q == BUS_ADDR);
  assign we_n   = !(low_ph && (kind_q != BUS_READ));
  assign re_n   = !(low_ph && (kind_q == BUS_READ));
  assign dq_oe  = act_q && (kind_q != BUS_READ);
  assign dq_o   = byte_q;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    byte_d = byte_q;
    rb_d   = rb_q;
    if (!act_q && start) begin
      act_d  = 1'b1;
      cnt_d  = '0;
      kind_d = kind;
      byte_d = wbyte;
    end else if (act_q) begin
      if (kind_q == BUS_READ && cnt_q == CW'(LO_CYC - 1)) rb_d = dq_i;
      if (ack) act_d = 1'b0;
      else     cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      kind_q <= BUS_CMD;
      byte_q <= '0;
      rb_q   <= '0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      byte_q <= byte_d;
      rb_q   <= rb_d;
    end
  end

  // R9: a start taken while idle drops one strobe in the next cycle
  p_start_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (!we_n || !re_n));
  // R9: each bus cycle completes once
  p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
endmodule

// File: rtl/nand_dual_plane_prog.sv
module nand_dual_plane_prog
  import nand_mp_pkg::*;
#(
  parameter int unsigned PAGE_BYTES     = 2112,
  parameter int unsigned PLANE_ROW_BIT  = 6,
  parameter int unsigned WE_LO          = 2,
  parameter int unsigned WE_HI          = 2,
  parameter int unsigned WB_CYCLES      = 4,
  parameter int unsigned TIMEOUT_CYCLES = 100000,
  parameter logic [7:0]  OP_SETUP       = 8'h80,
  parameter logic [7:0]  OP_CONF1       = 8'h11,
  parameter logic [7:0]  OP_MP_SETUP    = 8'h81,
  parameter logic [7:0]  OP_CONF2       = 8'h10,
  parameter logic [7:0]  OP_STATUS      = 8'h70,
  parameter logic [7:0]  OP_ENH_STATUS  = 8'h78
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [39:0] req_addr0,
  input  logic [39:0] req_addr1,
  input  logic        src_valid,
  output logic        src_ready,
  input  logic [7:0]  src_data,
  output logic        done,
  output logic        fail_plane0,
  output logic        fail_plane1,
  output logic        err_timeout,
  output logic        err_reject,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_o,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_i,
  input  logic        nand_rb_n
);
  localparam int unsigned PLANE_BIT = 16 + PLANE_ROW_BIT;
  localparam int unsigned IW        = $clog2(PAGE_BYTES + 1);

  seq_state_e            st_q, st_d;
  logic [IW-1:0]         idx_q, idx_d;
  logic                  ph_q, ph_d, pl_q, pl_d;
  logic [PAGE_ADDR_W-1:0] a0_q, a0_d, a1_q, a1_d;
  logic                  f0_q, f0_d, f1_q, f1_d, tmo_q, tmo_d, rej_q, rej_d;
  logic                  rb_m, rb_s;

  logic       eng_start, eng_busy, eng_ack;
  bus_kind_e  eng_kind;
  logic [7:0] eng_wbyte, eng_rbyte;
  logic       wb_exp, tmo_exp, accept, bad_plane;
  logic [PAGE_ADDR_W-1:0] cur_addr;

  function automatic logic [7:0] pick_byte(input logic [PAGE_ADDR_W-1:0] a,
                                           input logic [2:0] i);
    case (i)
      3'd0:    pick_byte = a[7:0];
      3'd1:    pick_byte = a[15:8];
      3'd2:    pick_byte = a[23:16];
      3'd3:    pick_byte = a[31:24];
      default: pick_byte = a[39:32];
    endcase
  endfunction

  // ready/busy from the device is asynchronous: two-stage synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_m <= 1'b0;
      rb_s <= 1'b0;
    end else begin
      rb_m <= nand_rb_n;
      rb_s <= rb_m;
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign bad_plane = req_addr0[PLANE_BIT] || !req_addr1[PLANE_BIT];
  assign done      = (st_q == S_FINISH);
  assign nand_ce_n = (st_q == S_IDLE) || (st_q == S_FINISH);
  assign cur_addr  = (st_q == S_ENH_ADDR) ? (pl_q ? a1_q : a0_q) : (ph_q ? a1_q : a0_q);
  assign src_ready = (st_q == S_DATA) && !eng_busy;
  assign {fail_plane0, fail_plane1, err_timeout, err_reject} = {f0_q, f1_q, tmo_q, rej_q};

  // bus cycle selection for the current state
  always_comb begin
    eng_kind  = BUS_CMD;
    eng_wbyte = 8'h00;
    case (st_q)
      S_C_SETUP:  eng_wbyte = ph_q ? OP_MP_SETUP : OP_SETUP;
      S_ADDR:     begin eng_kind = BUS_ADDR; eng_wbyte = pick_byte(cur_addr, idx_q[2:0]); end
      S_DATA:     begin eng_kind = BUS_DATA; eng_wbyte = src_data; end
      S_C_CONF:   eng_wbyte = ph_q ? OP_CONF2 : OP_CONF1;
      S_C_STAT:   eng_wbyte = OP_STATUS;
      S_C_ENH:    eng_wbyte = OP_ENH_STATUS;
      S_ENH_ADDR: begin eng_kind = BUS_ADDR; eng_wbyte = pick_byte(cur_addr, idx_q[2:0] + 3'd2); end
      S_RD_STAT, S_RD_ENH: eng_kind = BUS_READ;
      default: ;
    endcase
    case (st_q)
      S_C_SETUP, S_ADDR, S_C_CONF, S_C_STAT, S_RD_STAT, S_C_ENH, S_ENH_ADDR, S_RD_ENH:
        eng_start = !eng_busy;
      S_DATA:  eng_start = !eng_busy && src_valid;
      default: eng_start = 1'b0;
    endcase
  end

  // sequencing
  always_comb begin
    st_d = st_q; idx_d = idx_q; ph_d = ph_q; pl_d = pl_q;
    a0_d = a0_q; a1_d = a1_q;
    f0_d = f0_q; f1_d = f1_q; tmo_d = tmo_q; rej_d = rej_q;
    case (st_q)
      S_IDLE: if (accept) begin
        a0_d = req_addr0; a1_d = req_addr1;
        {f0_d, f1_d, tmo_d} = 3'b000;
        rej_d = bad_plane;
        ph_d  = 1'b0;
        st_d  = bad_plane ? S_FINISH : S_C_SETUP;
      end
      S_C_SETUP: if (eng_ack) begin idx_d = '0; st_d = S_ADDR; end
      S_ADDR: if (eng_ack) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == IW'(4)) begin idx_d = '0; st_d = S_DATA; end
      end
      S_DATA: if (eng_ack) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == IW'(PAGE_BYTES - 1)) st_d = S_C_CONF;
      end
      S_C_CONF: if (eng_ack) st_d = S_WAIT_WB;
      S_WAIT_WB: if (wb_exp) st_d = S_WAIT_RB;
      S_WAIT_RB:
        if (rb_s) begin
          if (ph_q) st_d = S_C_STAT;
          else begin ph_d = 1'b1; st_d = S_C_SETUP; end
        end else if (tmo_exp) begin
          tmo_d = 1'b1; st_d = S_FINISH;
        end
      S_C_STAT: if (eng_ack) st_d = S_RD_STAT;
      S_RD_STAT: if (eng_ack) begin
        if (!eng_rbyte[6]) begin
          if (tmo_exp) begin tmo_d = 1'b1; st_d = S_FINISH; end
          else st_d = S_C_STAT;
        end else if (eng_rbyte[0]) begin
          pl_d = 1'b0; st_d = S_C_ENH;
        end else st_d = S_FINISH;
      end
      S_C_ENH: if (eng_ack) begin idx_d = '0; st_d = S_ENH_ADDR; end
      S_ENH_ADDR: if (eng_ack) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == IW'(2)) st_d = S_RD_ENH;
      end
      S_RD_ENH: if (eng_ack) begin
        if (pl_q) begin f1_d = eng_rbyte[0]; st_d = S_FINISH; end
        else begin f0_d = eng_rbyte[0]; pl_d = 1'b1; st_d = S_C_ENH; end
      end
      S_FINISH: st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; idx_q <= '0; ph_q <= 1'b0; pl_q <= 1'b0;
      a0_q <= '0; a1_q <= '0;
      f0_q <= 1'b0; f1_q <= 1'b0; tmo_q <= 1'b0; rej_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; ph_q <= ph_d; pl_q <= pl_d;
      a0_q <= a0_d; a1_q <= a1_d;
      f0_q <= f0_d; f1_q <= f1_d; tmo_q <= tmo_d; rej_q <= rej_d;
    end
  end

  nand_wait_timer #(.LIMIT(WB_CYCLES)) u_wb_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr(st_q != S_WAIT_WB), .en(st_q == S_WAIT_WB), .expired(wb_exp));

  nand_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_rb_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr((st_q == S_IDLE) || (st_q == S_WAIT_WB)),
    .en((st_q == S_WAIT_RB) || (st_q == S_C_STAT) || (st_q == S_RD_STAT)),
    .expired(tmo_exp));

  nand_bus_cycle #(.LO_CYC(WE_LO), .HI_CYC(WE_HI)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .kind(eng_kind), .wbyte(eng_wbyte),
    .busy(eng_busy), .ack(eng_ack), .rbyte(eng_rbyte),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_o(nand_dq_o), .dq_oe(nand_dq_oe), .dq_i(nand_dq_i));

  // R1: idle handshake implies the chip is deselected
  p_ready_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> nand_ce_n);
  // R2: refused request finishes at once with the reject flag
  p_reject_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad_plane) |=> (done && err_reject && nand_ce_n));
  // R8: exhausted wait ends the operation
  p_timeout_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT_RB && tmo_exp && !rb_s) |=> (done && err_timeout));
  // R10: completion strobe lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: result flags hold while idle without a new request
  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> $stable({fail_plane0, fail_plane1, err_timeout, err_reject}));
  // R11: a consumed source byte launches a write pulse
  p_src_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready) |=> !nand_we_n);
endmodule

// File: tb/nand_dual_plane_prog_tb_top.sv
`timescale 1ns/1ps
module nand_dual_plane_prog_tb_top;
  localparam int PB = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [39:0] req_addr0 = '0, req_addr1 = '0;
  logic        src_valid, src_ready;
  logic [7:0]  src_data;
  logic        req_ready, done, fail_plane0, fail_plane1, err_timeout, err_reject;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o;
  logic [7:0]  nand_dq_i = 8'h00;
  logic        nand_rb_n = 1'b1;

  nand_dual_plane_prog #(.PAGE_BYTES(PB), .WB_CYCLES(3), .TIMEOUT_CYCLES(300)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr0(req_addr0), .req_addr1(req_addr1),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .done(done), .fail_plane0(fail_plane0), .fail_plane1(fail_plane1),
    .err_timeout(err_timeout), .err_reject(err_reject),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n));

  int checks = 0;
  int errors = 0;

  // byte source: value follows the consumed-byte counter, optional stalls
  int  src_k = 0;
  int  cyc = 0;
  logic gap_mode = 1'b0;
  assign src_valid = !(gap_mode && (cyc % 3 == 0));
  assign src_data  = 8'h30 + 8'(src_k * 5);
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (src_valid && src_ready) src_k <= src_k + 1;
  end

  // device model with bus-cycle log: kind 1 cmd, 2 addr, 3 data, 4 read
  int         n_log = 0;
  int         lg_kind [0:127];
  logic [7:0] lg_byte [0:127];
  logic [7:0] last_cmd = 8'h00;
  int         addr_seen = 0;
  logic       enh_plane = 1'b0;
  int         busy_len = 20;
  int         lag = 0;
  logic       m_fail0 = 1'b0, m_fail1 = 1'b0;

  always @(posedge nand_we_n) begin
    if (nand_ce_n === 1'b0) begin
      if (n_log < 128) begin
        lg_kind[n_log] = nand_cle ? 1 : (nand_ale ? 2 : 3);
        lg_byte[n_log] = nand_dq_o;
        n_log++;
      end
      if (nand_cle) begin
        last_cmd  = nand_dq_o;
        addr_seen = 0;
        if (nand_dq_o == 8'h11 || nand_dq_o == 8'h10) begin
          fork
            begin
              int n;
              n = busy_len;
              @(posedge clk);
              nand_rb_n = 1'b0;
              repeat (n) @(posedge clk);
              nand_rb_n = 1'b1;
            end
          join_none
        end
      end else if (nand_ale) begin
        if (addr_seen == 0) enh_plane = nand_dq_o[6];
        addr_seen++;
      end
    end
  end

  always @(negedge nand_re_n) begin
    if (nand_ce_n === 1'b0) begin
      if (last_cmd == 8'h78)
        nand_dq_i = {2'b11, 5'b0, enh_plane ? m_fail1 : m_fail0};
      else begin
        nand_dq_i = {1'b1, (lag != 0) ? 1'b0 : 1'b1, 5'b0, m_fail0 | m_fail1};
        if (lag != 0) lag--;
      end
      if (n_log < 128) begin
        lg_kind[n_log] = 4;
        lg_byte[n_log] = nand_dq_i;
        n_log++;
      end
    end
  end

  // expected sequence
  int         n_exp;
  int         ex_kind [0:127];
  logic [7:0] ex_byte [0:127];

  task automatic push(input int k, input logic [7:0] b);
    ex_kind[n_exp] = k;
    ex_byte[n_exp] = b;
    n_exp++;
  endtask

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_page(input logic [39:0] a, input int k0);
    for (int i = 0; i < 5; i++) push(2, a[8*i +: 8]);
    for (int i = 0; i < PB; i++) push(3, 8'h30 + 8'((k0 + i) * 5));
  endtask

  task automatic cmp_log(input string req);
    logic ok;
    int bad;
    ok  = (n_log == n_exp);
    bad = -1;
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      if (bad < 0 && (lg_kind[i] != ex_kind[i] ||
                      (ex_kind[i] != 4 && lg_byte[i] != ex_byte[i]))) bad = i;
    end
    chk(ok, req, "bus cycle count", 64'(n_log), 64'(n_exp));
    if (bad >= 0)
      chk(1'b0, req, $sformatf("bus cycle %0d kind/byte", bad),
          {32'(lg_kind[bad]), 24'h0, lg_byte[bad]}, {32'(ex_kind[bad]), 24'h0, ex_byte[bad]});
    else
      chk(1'b1, req, "bus cycle order", 64'd0, 64'd0);
  endtask

  // issue a request and wait for done; returns cycles from acceptance to done
  task automatic run_op(input logic [39:0] a0, input logic [39:0] a1,
                        input logic hold, output int cycles);
    while (nand_rb_n !== 1'b1) @(negedge clk);
    repeat (3) @(negedge clk);
    n_log = 0;
    req_addr0 = a0;
    req_addr1 = a1;
    req_valid = 1'b1;
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    cycles = 1;
    while (!done && cycles < 20000) begin
      @(negedge clk);
      cycles++;
    end
    req_valid = 1'b0;
  endtask

  localparam logic [39:0] A0 = {24'h012305, 16'h0040};
  localparam logic [39:0] A1 = {24'h0123C7, 16'h01A2};

  task automatic t_reset;
    chk(req_ready === 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
    chk(nand_ce_n === 1'b1, "R9", "ce_n after reset", 64'(nand_ce_n), 64'd1);
    chk({nand_cle, nand_ale, nand_we_n, nand_re_n} === 4'b0011, "R9", "strobes after reset",
        64'({nand_cle, nand_ale, nand_we_n, nand_re_n}), 64'h3);
    chk(done === 1'b0, "R10", "done after reset", 64'(done), 64'd0);
  endtask

  // pass case with request held across done (R1, R3, R4, R5, R6, R10)
  task automatic t_pass_held;
    int c, k0;
    m_fail0 = 0; m_fail1 = 0; lag = 0; busy_len = 20;
    k0 = src_k;
    n_exp = 0;
    push(1, 8'h80); push_page(A0, k0); push(1, 8'h11);
    push(1, 8'h81); push_page(A1, k0 + PB); push(1, 8'h10);
    push(1, 8'h70); push(4, 8'h00);
    run_op(A0, A1, 1'b1, c);
    chk(done === 1'b1, "R6", "done reached", 64'(done), 64'd1);
    chk(req_ready === 1'b0, "R1", "req_ready during done", 64'(req_ready), 64'd0);
    chk({fail_plane0, fail_plane1, err_timeout, err_reject} === 4'b0000, "R6", "pass flags",
        64'({fail_plane0, fail_plane1, err_timeout, err_reject}), 64'd0);
    @(negedge clk);
    chk(done === 1'b0, "R10", "done one cycle", 64'(done), 64'd0);
    chk(req_ready === 1'b1, "R1", "req_ready after done", 64'(req_ready), 64'd1);
    cmp_log("R3 R4 R1");
  endtask

  // plane 1 fails, polling lag, stalled source (R5, R7, R11, R10)
  task automatic t_fail_plane1;
    int c, k0;
    m_fail0 = 0; m_fail1 = 1; lag = 2; busy_len = 15; gap_mode = 1;
    k0 = src_k;
    n_exp = 0;
    push(1, 8'h80); push_page(A0, k0); push(1, 8'h11);
    push(1, 8'h81); push_page(A1, k0 + PB); push(1, 8'h10);
    for (int i = 0; i < 3; i++) begin push(1, 8'h70); push(4, 8'h00); end
    push(1, 8'h78); for (int i = 2; i < 5; i++) push(2, A0[8*i +: 8]); push(4, 8'h00);
    push(1, 8'h78); for (int i = 2; i < 5; i++) push(2, A1[8*i +: 8]); push(4, 8'h00);
    run_op(A0, A1, 1'b0, c);
    gap_mode = 0;
    chk({fail_plane0, fail_plane1} === 2'b01, "R7", "per-plane fail flags",
        64'({fail_plane0, fail_plane1}), 64'h1);
    chk(err_timeout === 1'b0, "R7", "no timeout on fail", 64'(err_timeout), 64'd0);
    cmp_log("R5 R7 R11");
    chk(src_k == k0 + 2 * PB, "R11", "bytes consumed", 64'(src_k - k0), 64'(2 * PB));
    repeat (4) @(negedge clk);
    chk({fail_plane0, fail_plane1} === 2'b01, "R10", "flags held idle",
        64'({fail_plane0, fail_plane1}), 64'h1);
  endtask

  // both planes fail (R7)
  task automatic t_fail_both;
    int c;
    m_fail0 = 1; m_fail1 = 1; lag = 0; busy_len = 10;
    run_op(A0, A1, 1'b0, c);
    chk({fail_plane0, fail_plane1} === 2'b11, "R7", "both planes fail",
        64'({fail_plane0, fail_plane1}), 64'h3);
    chk(n_log == 2 * (PB + 7) + 2 + 2 * 5, "R7", "enhanced reads issued",
        64'(n_log), 64'(2 * (PB + 7) + 12));
  endtask

  // plane-bit violations (R2)
  task automatic t_reject;
    int c;
    logic [39:0] bad0, bad1;
    bad0 = A0; bad0[22] = 1'b1;
    run_op(bad0, A1, 1'b0, c);
    chk(c == 1, "R2", "reject latency", 64'(c), 64'd1);
    chk(err_reject === 1'b1 && fail_plane0 === 1'b0, "R2", "reject flag", 64'(err_reject), 64'd1);
    chk(n_log == 0, "R2", "no bus cycle on bad addr0", 64'(n_log), 64'd0);
    bad1 = A1; bad1[22] = 1'b0;
    run_op(A0, bad1, 1'b0, c);
    chk(err_reject === 1'b1 && n_log == 0, "R2", "reject on bad addr1",
        64'(n_log), 64'd0);
  endtask

  // device stays busy after first confirm (R8)
  task automatic t_timeout;
    int c, k0;
    m_fail0 = 0; m_fail1 = 0; lag = 0; busy_len = 1000;
    k0 = src_k;
    n_exp = 0;
    push(1, 8'h80); push_page(A0, k0); push(1, 8'h11);
    run_op(A0, A1, 1'b0, c);
    chk(err_timeout === 1'b1 && err_reject === 1'b0, "R8", "timeout flag",
        64'({err_timeout, err_reject}), 64'h2);
    cmp_log("R8");
    busy_len = 20;
    while (nand_rb_n !== 1'b1) @(negedge clk);
    chk(n_log == n_exp, "R8", "silent after timeout", 64'(n_log), 64'(n_exp));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass_held();
    t_fail_plane1();
    t_fail_both();
    t_reject();
    t_timeout();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule